// File: doc/BRIEF.md
# Self-Triggered Segment Buffer Manager

This block keeps track of short waveform segments captured on a self-trigger, so that acquisition can go on while earlier captures are still being read out. A small pool of segment slots is used as a ring. The slot being written is shown on `wr_seg_o` for the sampling front end. A trigger closes that slot and stores a copy of a free-running coarse time counter in it. The write side then moves on to the next slot.

A reader works through the ring from its own pointer at the same time. When at least one closed segment has not been read and the reader is idle, `seg_rdy_o` goes high. The slot number and its coarse timestamp are then shown on the outputs. The downstream processor answers with `seg_ack_i`. The block then steps a sample address through the segment, one address per readout period, for a count that is set on each acknowledge.

Triggers that arrive while every slot holds unread data are dropped and counted. Capture never waits for readout, and readout is driven only by data being present.

Top module: `segbuf_mgr`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `seg_rdy_o` and `samp_vld_o` are 0, `wr_seg_o` is 0 and `ovf_cnt_o` is 0.
- R2: The coarse counter is 0 in reset and counts up by one on each clock edge after that, wrapping at 2^TS_W. An accepted trigger stores the value the counter held in the trigger cycle. That value appears on `seg_ts_o` when the segment is offered.
- R3: Each clock cycle with `trig_i` high counts as one trigger. When NSEG segments are stored and unread, the trigger changes no slot and `wr_seg_o` stays the same. `ovf_cnt_o` goes up by one for each such trigger and stops at its all-ones value.
- R4: Each accepted trigger moves `wr_seg_o` to the next slot, modulo NSEG, from the cycle after the trigger.
- R5: `seg_rdy_o` is high exactly when the reader is idle and an unread segment exists. Segments are offered in capture order, and `seg_idx_o` shows the slot number.
- R6: A handshake (`seg_rdy_o` and `seg_ack_i` both high at an edge) starts readout. From the next cycle `samp_vld_o` pulses once every RD_PERIOD cycles, with `samp_addr_o` running 0, 1, … up to `rd_len_i`. The segment is then released.
- R7: `rd_len_i` gives the sample count minus one (0 means one sample, 31 means 32 samples). It is taken only at the handshake, and changes during readout have no effect.
- R8: `seg_ack_i` while `seg_rdy_o` is low starts no readout, and no `samp_vld_o` pulse follows.
- R9: Triggers are accepted while a segment is being read, with no dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Self-trigger, one per cycle high |
| rd_len_i | input | $clog2(SAMP) | Samples to read minus one |
| seg_ack_i | input | 1 | Downstream takes the offered segment |
| seg_rdy_o | output | 1 | Unread segment offered |
| seg_idx_o | output | $clog2(NSEG) | Slot of the offered or active segment |
| seg_ts_o | output | TS_W | Coarse timestamp of that slot |
| samp_vld_o | output | 1 | Sample address valid this cycle |
| samp_addr_o | output | $clog2(SAMP) | Sample address within the segment |
| wr_seg_o | output | $clog2(NSEG) | Slot currently being written |
| ovf_cnt_o | output | OVF_W | Dropped-trigger count, saturating |

## Verification
The bench fills the ring with the reader held off and keeps triggering. A wrong full test would overwrite the oldest stamp or wrap the write slot. A wrong counter would show the wrong drop count, or wrap to zero instead of holding at its top value. Segments are then drained with the length input changed in mid-read. A reader that kept sampling the input would produce the wrong number of valid pulses. The bench also sends an acknowledge to an empty ring, where a careless handshake would start a phantom readout. Finally it fires triggers in the middle of 32-sample reads and of 1-sample reads. This catches a design that blocks capture during readout, and off-by-one errors in the stamp cycle or in the last address.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
   typedef enum logic [0:0] {
      RD_IDLE = 1'b0,
      RD_RUN  = 1'b1
   } rd_state_e;
endpackage

// File: rtl/segbuf_timer.sv
module segbuf_timer #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] cnt_o
);
   initial assert (TS_W >= 2) else $error("TS_W too small");

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_o + 1'b1;
   end

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/segbuf_ring.sv
module segbuf_ring #(
   parameter int NSEG     = 4,
   parameter int TS_W     = 16,
   parameter int OVF_W    = 8,
   parameter bit OVF_SAT  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    trig_i,
   input  logic [TS_W-1:0]         stamp_i,
   input  logic                    rd_done_i,
   output logic [$clog2(NSEG)-1:0] wr_idx_o,
   output logic [$clog2(NSEG)-1:0] rd_idx_o,
   output logic [TS_W-1:0]         rd_ts_o,
   output logic                    empty_o,
   output logic                    full_o,
   output logic [OVF_W-1:0]        ovf_o
);
   localparam int IW = $clog2(NSEG);
   localparam int PW = IW + 1;

   initial begin
      assert (NSEG >= 2 && (1 << IW) == NSEG) else $error("NSEG must be a power of two >= 2");
      assert (OVF_W >= 1) else $error("OVF_W must be positive");
   end

   logic [PW-1:0]   wp_q, rp_q;
   logic [TS_W-1:0] ts_q [NSEG];
   logic            accept;

   assign full_o   = (wp_q[IW] != rp_q[IW]) && (wp_q[IW-1:0] == rp_q[IW-1:0]);
   assign empty_o  = (wp_q == rp_q);
   assign accept   = trig_i && !full_o;
   assign wr_idx_o = wp_q[IW-1:0];
   assign rd_idx_o = rp_q[IW-1:0];
   assign rd_ts_o  = ts_q[rp_q[IW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (accept)               wp_q <= wp_q + 1'b1;
         if (rd_done_i && !empty_o) rp_q <= rp_q + 1'b1;
      end
   end

   for (genvar g = 0; g < NSEG; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                                wp_unused_reset(g);
         else if (accept && wp_q[IW-1:0] == IW'(g)) ts_q[g] <= stamp_i;
      end
   end

   function automatic void wp_unused_reset(int slot);
      // stamps carry no meaning until written, so reset leaves them alone
      if (slot < 0) $display("unreachable");
   endfunction

   logic trig_drop;
   assign trig_drop = trig_i && full_o;

   if (OVF_SAT) begin : g_ovf_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                     ovf_o <= '0;
         else if (trig_drop && ~&ovf_o)  ovf_o <= ovf_o + 1'b1;
      end
   end else begin : g_ovf_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)         ovf_o <= '0;
         else if (trig_drop) ovf_o <= ovf_o + 1'b1;
      end
   end

   p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && full_o) |=> $stable(wp_q));
   p_ovf_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && full_o && ~&ovf_o) |=> ovf_o == $past(ovf_o) + 1'b1);
   p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !full_o) |=> wp_q == $past(wp_q) + 1'b1);
   p_stamp_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !full_o) |=> ts_q[$past(wp_q[IW-1:0])] == $past(stamp_i));
   p_occupancy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      PW'(wp_q - rp_q) <= PW'(NSEG));
endmodule

// File: rtl/segbuf_reader.sv
module segbuf_reader
   import segbuf_pkg::*;
#(
   parameter int SAMP      = 32,
   parameter int RD_PERIOD = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    avail_i,
   input  logic                    ack_i,
   input  logic [$clog2(SAMP)-1:0] len_m1_i,
   output logic                    rdy_o,
   output logic                    done_o,
   output logic                    samp_vld_o,
   output logic [$clog2(SAMP)-1:0] samp_addr_o
);
   localparam int AW  = $clog2(SAMP);
   localparam int PCW = (RD_PERIOD > 1) ? $clog2(RD_PERIOD) : 1;
   localparam logic [AW-1:0] LEN_MAX = AW'(SAMP - 1);

   initial begin
      assert (SAMP >= 2) else $error("SAMP must be at least 2");
      assert (RD_PERIOD >= 1) else $error("RD_PERIOD must be positive");
   end

   rd_state_e      state_q;
   logic [AW-1:0]  addr_q, len_q;
   logic [PCW-1:0] pc_q;
   logic           start, tick;

   assign rdy_o       = (state_q == RD_IDLE) && avail_i;
   assign start       = rdy_o && ack_i;
   assign samp_vld_o  = (state_q == RD_RUN) && (pc_q == '0);
   assign samp_addr_o = addr_q;
   assign done_o      = (state_q == RD_RUN) && tick && (addr_q == len_q);

   if (RD_PERIOD > 1) begin : g_div
      assign tick = (pc_q == PCW'(RD_PERIOD - 1));
      always_ff @(posedge clk) begin
         if (!rst_n || start)        pc_q <= '0;
         else if (state_q == RD_RUN) pc_q <= tick ? '0 : pc_q + 1'b1;
      end
   end else begin : g_nodiv
      assign tick = 1'b1;
      assign pc_q = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         addr_q  <= '0;
         len_q   <= '0;
      end else if (start) begin
         state_q <= RD_RUN;
         addr_q  <= '0;
         len_q   <= (len_m1_i > LEN_MAX) ? LEN_MAX : len_m1_i;
      end else if (state_q == RD_RUN && tick) begin
         if (addr_q == len_q) state_q <= RD_IDLE;
         else                 addr_q  <= addr_q + 1'b1;
      end
   end

   p_addr_in_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      samp_vld_o |-> samp_addr_o <= len_q);
   p_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_IDLE && !avail_i) |=> !samp_vld_o);
   p_first_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (samp_vld_o && samp_addr_o == '0));
   p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RD_RUN && !done_o) |=> $stable(len_q));
endmodule

// File: rtl/segbuf_mgr.sv
module segbuf_mgr #(
   parameter int NSEG      = 4,
   parameter int SAMP      = 32,
   parameter int TS_W      = 16,
   parameter int OVF_W     = 8,
   parameter int RD_PERIOD = 2,
   parameter bit OVF_SAT   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    trig_i,
   input  logic [$clog2(SAMP)-1:0] rd_len_i,
   input  logic                    seg_ack_i,
   output logic                    seg_rdy_o,
   output logic [$clog2(NSEG)-1:0] seg_idx_o,
   output logic [TS_W-1:0]         seg_ts_o,
   output logic                    samp_vld_o,
   output logic [$clog2(SAMP)-1:0] samp_addr_o,
   output logic [$clog2(NSEG)-1:0] wr_seg_o,
   output logic [OVF_W-1:0]        ovf_cnt_o
);
   logic [TS_W-1:0] stamp;
   logic            empty, full, rd_done;

   segbuf_timer #(.TS_W(TS_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_o (stamp)
   );

   segbuf_ring #(
      .NSEG(NSEG), .TS_W(TS_W), .OVF_W(OVF_W), .OVF_SAT(OVF_SAT)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig_i),
      .stamp_i   (stamp),
      .rd_done_i (rd_done),
      .wr_idx_o  (wr_seg_o),
      .rd_idx_o  (seg_idx_o),
      .rd_ts_o   (seg_ts_o),
      .empty_o   (empty),
      .full_o    (full),
      .ovf_o     (ovf_cnt_o)
   );

   segbuf_reader #(.SAMP(SAMP), .RD_PERIOD(RD_PERIOD)) u_reader (
      .clk         (clk),
      .rst_n       (rst_n),
      .avail_i     (!empty),
      .ack_i       (seg_ack_i),
      .len_m1_i    (rd_len_i),
      .rdy_o       (seg_rdy_o),
      .done_o      (rd_done),
      .samp_vld_o  (samp_vld_o),
      .samp_addr_o (samp_addr_o)
   );

   p_rdy_not_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seg_rdy_o |-> !empty);
   p_trig_during_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !full && samp_vld_o) |=> wr_seg_o != $past(wr_seg_o));
endmodule

// File: tb/segbuf_mgr_bench.sv
module segbuf_mgr_bench;
   localparam int NSEG = 4, SAMP = 32, TS_W = 16, OVF_W = 8, P = 2;
   localparam int AW = $clog2(SAMP), IW = $clog2(NSEG);

   logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, ack = 1'b0;
   logic [AW-1:0] rd_len = '0;
   logic seg_rdy, samp_vld;
   logic [IW-1:0] seg_idx, wr_seg;
   logic [TS_W-1:0] seg_ts;
   logic [AW-1:0] samp_addr;
   logic [OVF_W-1:0] ovf;

   segbuf_mgr #(.NSEG(NSEG), .SAMP(SAMP), .TS_W(TS_W), .OVF_W(OVF_W),
                .RD_PERIOD(P), .OVF_SAT(1'b1)) u_segbuf_mgr (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .rd_len_i(rd_len),
      .seg_ack_i(ack), .seg_rdy_o(seg_rdy), .seg_idx_o(seg_idx),
      .seg_ts_o(seg_ts), .samp_vld_o(samp_vld), .samp_addr_o(samp_addr),
      .wr_seg_o(wr_seg), .ovf_cnt_o(ovf));

   always #4 clk = ~clk;

   typedef struct packed { logic [IW-1:0] idx; logic [TS_W-1:0] ts; } item_t;
   item_t exp_q[$];
   int n_chk = 0, n_fail = 0, edges = 0, acc = 0;
   bit finished = 1'b0;

   always @(posedge clk) if (rst_n) edges <= edges + 1;

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: one trigger cycle; pushes the expected stamp when it should be accepted
   task automatic fire(bit expect_accept);
      @(negedge clk);
      trig = 1'b1;
      if (expect_accept) begin
         exp_q.push_back('{idx: IW'(acc), ts: TS_W'(edges)});
         acc++;
      end
      @(negedge clk);
      trig = 1'b0;
   endtask

   // monitor: take one segment, compare against the scoreboard and walk its samples
   task automatic read_one(int len, int junk_len);
      item_t e;
      int guard = 0;
      bit ok = 1'b1;
      int bad_addr = -1;
      while (!seg_rdy && guard < 2000) begin @(negedge clk); guard++; end
      chk(seg_rdy, "R5 segment offered", seg_rdy, 1);
      e = exp_q.pop_front();
      chk(seg_idx == e.idx, "R5 slot order", seg_idx, e.idx);
      chk(seg_ts == e.ts, "R2 stamp", seg_ts, e.ts);
      rd_len = AW'(len);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      rd_len = AW'(junk_len);   // R7: must not change the count
      for (int i = 0; i <= len; i++) begin
         if (!(samp_vld && samp_addr == AW'(i))) begin ok = 1'b0; bad_addr = samp_addr; end
         for (int k = 1; k < P; k++) begin
            @(negedge clk);
            if (samp_vld) ok = 1'b0;
         end
         @(negedge clk);
      end
      chk(ok, "R6 sample sequence", bad_addr, len);
      chk(!samp_vld, "R7 count fixed at handshake", samp_vld, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!seg_rdy && !samp_vld, "R1 idle in reset", seg_rdy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!seg_rdy && !samp_vld, "R1 outputs after reset", samp_vld, 0);
      chk(wr_seg == 0, "R1 write slot", wr_seg, 0);
      chk(ovf == 0, "R1 overflow count", ovf, 0);

      // R8: acknowledge into an empty ring
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      begin
         bit seen = 1'b0;
         repeat (5) begin @(negedge clk); if (samp_vld || seg_rdy) seen = 1'b1; end
         chk(!seen, "R8 ack ignored when not ready", seen, 0);
      end

      // fill the ring with the reader idle
      for (int n = 0; n < NSEG; n++) begin
         fire(1'b1);
         chk(wr_seg == IW'(acc), "R4 write slot advance", wr_seg, IW'(acc));
         @(negedge clk);
      end
      chk(seg_rdy, "R5 ready with data", seg_rdy, 1);
      fire(1'b0);
      fire(1'b0);
      chk(ovf == 2, "R3 drop count", ovf, 2);
      chk(wr_seg == 0, "R3 write slot unchanged", wr_seg, 0);
      @(negedge clk);
      trig = 1'b1;
      repeat (300) @(negedge clk);
      trig = 1'b0;
      chk(ovf == 8'hFF, "R3 saturation", ovf, 255);
      chk(wr_seg == 0, "R3 slot still unchanged", wr_seg, 0);

      // drain the oldest four stamps, length changed mid-read
      read_one(2, 9);
      read_one(0, 31);
      read_one(31, 0);
      read_one(5, 1);
      chk(!seg_rdy, "R5 ring drained", seg_rdy, 0);

      // concurrent capture and readout
      fork
         begin
            for (int b = 0; b < 3; b++) begin
               fire(1'b1);
               repeat (3) @(negedge clk);
               fire(1'b1);
               chk(wr_seg == IW'(acc), "R9 capture during readout", wr_seg, IW'(acc));
               repeat (150) @(negedge clk);
            end
         end
         begin
            for (int k = 0; k < 6; k++) read_one((k % 2 == 0) ? 31 : 0, 7);
         end
      join
      chk(ovf == 8'hFF, "R3 no drop while not full", ovf, 255);
      chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule